// File: doc/BRIEF.md
# Region-Aware Activation/Precharge Timer

This block lives inside a DRAM memory controller. For every row activation or precharge it picks the number of controller cycles that must pass before the bank may take its next command. The choice depends on where the row lies. Memory rows are grouped into regions by their upper address bits. An externally supplied profile marks each region as fast, meaning it holds no slow cells, or as slow. Fast regions get the reduced delays and slow regions the standard ones. The default delays assume a 2.5 ns controller clock: 7.5 ns rounds to 3 cycles and roughly 13 ns rounds up to 6 cycles.

The controller loads the profile one region at a time through a small write port. It holds a loading flag high for the whole time the profile is being rewritten, and during that time every access falls back to standard timing. The four delay values can be reprogrammed. Each bank has its own pair of down-counters. A counter is loaded when the bank receives a command and drives a ready output back to the arbiter.

Top module: `dram_region_timer`

## Requirements
- R1: After reset every region is marked slow, the four delay registers hold standard = 6 and fast = 3, and all `col_ready` and `act_ready` bits are high.
- R2: The region of a row is its top REGION_BITS bits, which are `cmd_row[13:11]` at the defaults. A profile bit of 1 marks the region fast.
- R3: `cur_trcd` and `cur_trp` show the fast activation and precharge delays when the current row lies in a fast region, and the standard delays otherwise.
- R4: While `prof_loading` is high, `cur_trcd` and `cur_trp` show the standard delays whatever the profile holds, and commands are timed with those delays.
- R5: An activation accepted on a clock edge (`cmd_valid`=1, `cmd_is_act`=1) drives `col_ready[bank]` low for exactly `cur_trcd` cycles. The bit is high again from the `cur_trcd`-th edge after the accepting edge.
- R6: A precharge accepted on a clock edge (`cmd_valid`=1, `cmd_is_act`=0) drives `act_ready[bank]` low for exactly `cur_trp` cycles in the same way.
- R7: A command touches only the counter that belongs to its own bank and its own kind. Other banks, and the other counter of the same bank, keep their ready state.
- R8: A write with `cfg_we`=1 sets one delay register selected by `cfg_sel`: 0 = standard activation, 1 = standard precharge, 2 = fast activation, 3 = fast precharge. The new value is in use from the next cycle.
- R9: A write with `prof_we`=1 sets the bit of region `prof_idx` to `prof_fast`. The change is in use from the next cycle and leaves every other region unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prof_we | input | 1 | Profile bit write strobe |
| prof_idx | input | REGION_BITS (3) | Region written |
| prof_fast | input | 1 | New class of that region (1 = fast) |
| prof_loading | input | 1 | Profile update in progress; forces standard delays |
| cfg_we | input | 1 | Delay register write strobe |
| cfg_sel | input | 2 | Delay register select (see R8) |
| cfg_val | input | CNT_W (4) | Delay value in cycles |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_is_act | input | 1 | 1 = activation, 0 = precharge |
| cmd_bank | input | BANK_BITS (2) | Target bank |
| cmd_row | input | ROW_W (14) | Row address of the command |
| cur_trcd | output | CNT_W (4) | Activation delay for the current row |
| cur_trp | output | CNT_W (4) | Precharge delay for the current row |
| col_ready | output | NUM_BANKS (4) | Per bank: a column command may be issued |
| act_ready | output | NUM_BANKS (4) | Per bank: an activation may be issued |

## Verification
`cur_trcd` and `cur_trp` are combinational from the command inputs, so the bench reads them at the falling edge of the same cycle in which it drives a row. Profile and delay writes land on the next rising edge, so their effect is checked one cycle later. For R5 and R6 the bench drives the command at a falling edge and lets one rising edge accept it. It then counts the falling edges at which the ready bit is still low, and that count must equal the selected delay exactly. The bits not addressed by the command are checked at the same sample points.

// File: rtl/dram_rt_pkg.sv
package dram_rt_pkg;
  typedef enum logic [1:0] {
    SEL_STD_RCD  = 2'd0,
    SEL_STD_RP   = 2'd1,
    SEL_FAST_RCD = 2'd2,
    SEL_FAST_RP  = 2'd3
  } delay_sel_e;
endpackage

// File: rtl/rt_region_profile.sv
module rt_region_profile #(
  parameter int ROW_W       = 14,
  parameter int REGION_BITS = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [REGION_BITS-1:0] wr_idx,
  input  logic                   wr_fast,
  input  logic [ROW_W-1:0]       look_row,
  output logic                   look_fast
);
  localparam int NUM_REGIONS = 1 << REGION_BITS;

  function automatic logic [REGION_BITS-1:0] region_of(input logic [ROW_W-1:0] row);
    return row[ROW_W-1 -: REGION_BITS];
  endfunction

  logic [NUM_REGIONS-1:0] fast_q;

  always_ff @(posedge clk) begin
    if (!rst_n) fast_q <= '0;
    else if (wr_en) fast_q[wr_idx] <= wr_fast;
  end

  assign look_fast = fast_q[region_of(look_row)];

  assert_profile_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> fast_q[$past(wr_idx)] == $past(wr_fast));
endmodule

// File: rtl/rt_timing_select.sv
module rt_timing_select #(
  parameter int CNT_W = 4
) (
  input  logic             region_fast,
  input  logic             fallback,
  input  logic [CNT_W-1:0] std_rcd,
  input  logic [CNT_W-1:0] std_rp,
  input  logic [CNT_W-1:0] fast_rcd,
  input  logic [CNT_W-1:0] fast_rp,
  output logic             use_fast,
  output logic [CNT_W-1:0] trcd,
  output logic [CNT_W-1:0] trp
);
  function automatic logic [CNT_W-1:0] pick(input logic f,
                                            input logic [CNT_W-1:0] s,
                                            input logic [CNT_W-1:0] q);
    return f ? q : s;
  endfunction

  assign use_fast = region_fast && !fallback;
  assign trcd     = pick(use_fast, std_rcd, fast_rcd);
  assign trp      = pick(use_fast, std_rp, fast_rp);
endmodule

// File: rtl/rt_bank_timer.sv
module rt_bank_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_rcd,
  input  logic             load_rp,
  input  logic [CNT_W-1:0] rcd_val,
  input  logic [CNT_W-1:0] rp_val,
  output logic             col_ready,
  output logic             act_ready
);
  logic [CNT_W-1:0] rcd_cnt, rp_cnt;

  function automatic logic [CNT_W-1:0] step(input logic ld,
                                            input logic [CNT_W-1:0] v,
                                            input logic [CNT_W-1:0] c);
    if (ld) return v;
    if (c != '0) return c - 1'b1;
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcd_cnt <= '0;
      rp_cnt  <= '0;
    end else begin
      rcd_cnt <= step(load_rcd, rcd_val, rcd_cnt);
      rp_cnt  <= step(load_rp, rp_val, rp_cnt);
    end
  end

  assign col_ready = (rcd_cnt == '0);
  assign act_ready = (rp_cnt == '0);

  assert_act_blocks_col_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_rcd && rcd_val != '0) |=> !col_ready);
  assert_rcd_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_rcd && rcd_cnt != '0) |=> rcd_cnt == $past(rcd_cnt) - 1'b1);
  assert_pre_blocks_act_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_rp && rp_val != '0) |=> !act_ready);
  assert_idle_col_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_rcd && col_ready) |=> col_ready);
  assert_idle_act_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_rp && act_ready) |=> act_ready);
endmodule

// File: rtl/dram_region_timer.sv
module dram_region_timer
  import dram_rt_pkg::*;
#(
  parameter int ROW_W       = 14,
  parameter int REGION_BITS = 3,
  parameter int NUM_BANKS   = 4,
  parameter int CNT_W       = 4,
  parameter int STD_CYC     = 6,
  parameter int FAST_CYC    = 3,
  localparam int BANK_BITS  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   prof_we,
  input  logic [REGION_BITS-1:0] prof_idx,
  input  logic                   prof_fast,
  input  logic                   prof_loading,
  input  logic                   cfg_we,
  input  logic [1:0]             cfg_sel,
  input  logic [CNT_W-1:0]       cfg_val,
  input  logic                   cmd_valid,
  input  logic                   cmd_is_act,
  input  logic [BANK_BITS-1:0]   cmd_bank,
  input  logic [ROW_W-1:0]       cmd_row,
  output logic [CNT_W-1:0]       cur_trcd,
  output logic [CNT_W-1:0]       cur_trp,
  output logic [NUM_BANKS-1:0]   col_ready,
  output logic [NUM_BANKS-1:0]   act_ready
);
  logic [CNT_W-1:0] std_rcd_q, std_rp_q, fast_rcd_q, fast_rp_q;
  logic             region_fast, use_fast;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      std_rcd_q  <= CNT_W'(STD_CYC);
      std_rp_q   <= CNT_W'(STD_CYC);
      fast_rcd_q <= CNT_W'(FAST_CYC);
      fast_rp_q  <= CNT_W'(FAST_CYC);
    end else if (cfg_we) begin
      case (delay_sel_e'(cfg_sel))
        SEL_STD_RCD:  std_rcd_q  <= cfg_val;
        SEL_STD_RP:   std_rp_q   <= cfg_val;
        SEL_FAST_RCD: fast_rcd_q <= cfg_val;
        default:      fast_rp_q  <= cfg_val;
      endcase
    end
  end

  rt_region_profile #(.ROW_W(ROW_W), .REGION_BITS(REGION_BITS)) u_profile (
    .clk(clk), .rst_n(rst_n), .wr_en(prof_we), .wr_idx(prof_idx),
    .wr_fast(prof_fast), .look_row(cmd_row), .look_fast(region_fast)
  );

  rt_timing_select #(.CNT_W(CNT_W)) u_select (
    .region_fast(region_fast), .fallback(prof_loading),
    .std_rcd(std_rcd_q), .std_rp(std_rp_q),
    .fast_rcd(fast_rcd_q), .fast_rp(fast_rp_q),
    .use_fast(use_fast), .trcd(cur_trcd), .trp(cur_trp)
  );

  logic act_cmd, pre_cmd;
  assign act_cmd = cmd_valid && cmd_is_act;
  assign pre_cmd = cmd_valid && !cmd_is_act;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (cmd_bank == BANK_BITS'(b));
    rt_bank_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .load_rcd(act_cmd && hit), .load_rp(pre_cmd && hit),
      .rcd_val(cur_trcd), .rp_val(cur_trp),
      .col_ready(col_ready[b]), .act_ready(act_ready[b])
    );
  end

  assert_fallback_std_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prof_loading |-> (cur_trcd == std_rcd_q && cur_trp == std_rp_q && !use_fast));
  assert_class_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    use_fast |-> (cur_trcd == fast_rcd_q && cur_trp == fast_rp_q));
endmodule

// File: tb/dram_region_timer_test.sv
module dram_region_timer_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       prof_we = 0, prof_fast = 0, prof_loading = 0;
  logic [2:0] prof_idx = 0;
  logic       cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [3:0] cfg_val = 0;
  logic       cmd_valid = 0, cmd_is_act = 0;
  logic [1:0] cmd_bank = 0;
  logic [13:0] cmd_row = 0;
  logic [3:0] cur_trcd, cur_trp;
  logic [3:0] col_ready, act_ready;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dram_region_timer uut (
    .clk(clk), .rst_n(rst_n), .prof_we(prof_we), .prof_idx(prof_idx),
    .prof_fast(prof_fast), .prof_loading(prof_loading), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_val(cfg_val), .cmd_valid(cmd_valid),
    .cmd_is_act(cmd_is_act), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .cur_trcd(cur_trcd), .cur_trp(cur_trp),
    .col_ready(col_ready), .act_ready(act_ready)
  );

  function automatic logic [13:0] row_in(input int region, input int offset);
    return 14'((region << 11) + offset);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_profile(input int region, input bit fast);
    @(negedge clk);
    prof_we = 1; prof_idx = 3'(region); prof_fast = fast;
    @(negedge clk);
    prof_we = 0;
  endtask

  task automatic set_delay(input int sel, input int val);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_val = 4'(val);
    @(negedge clk);
    cfg_we = 0;
  endtask

  // Issues one command and returns the number of sampled cycles its ready bit stays low.
  task automatic issue(input bit act, input int bank, input logic [13:0] row,
                       output int low, output logic [3:0] other_col,
                       output logic [3:0] other_act);
    @(negedge clk);
    cmd_valid = 1; cmd_is_act = act; cmd_bank = 2'(bank); cmd_row = row;
    @(negedge clk);
    cmd_valid = 0;
    other_col = col_ready; other_act = act_ready;
    low = 0;
    while (((act ? col_ready[bank] : act_ready[bank]) == 1'b0) && low < 40) begin
      low++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    cmd_row = row_in(2, 5);
    #1;
    chk("R1 trcd after reset", cur_trcd, 6);
    chk("R1 trp after reset", cur_trp, 6);
    chk("R1 col_ready after reset", col_ready, 4'hF);
    chk("R1 act_ready after reset", act_ready, 4'hF);
  endtask

  task automatic t_select;
    set_profile(2, 1);
    set_profile(5, 1);
    cmd_row = row_in(2, 0); #1;
    chk("R3 fast trcd", cur_trcd, 3);
    chk("R3 fast trp", cur_trp, 3);
    cmd_row = row_in(3, 0); #1;
    chk("R2 first row of slow region 3", cur_trcd, 6);
    cmd_row = row_in(3, -1); #1;
    chk("R2 last row of fast region 2", cur_trcd, 3);
    cmd_row = row_in(5, 2047); #1;
    chk("R2 last row of fast region 5", cur_trp, 3);
    cmd_row = row_in(6, 0); #1;
    chk("R9 untouched region 6 stays slow", cur_trp, 6);
  endtask

  task automatic t_act_pre;
    int n; logic [3:0] oc, oa;
    issue(1, 0, row_in(2, 7), n, oc, oa);
    chk("R5 fast activation delay", n, 3);
    issue(1, 1, row_in(0, 9), n, oc, oa);
    chk("R5 slow activation delay", n, 6);
    issue(0, 2, row_in(5, 1), n, oc, oa);
    chk("R6 fast precharge delay", n, 3);
    issue(0, 2, row_in(7, 1), n, oc, oa);
    chk("R6 slow precharge delay", n, 6);
  endtask

  task automatic t_independent;
    int n; logic [3:0] oc, oa;
    issue(1, 3, row_in(1, 0), n, oc, oa);
    chk("R7 other banks col_ready after activation", oc[2:0], 3'b111);
    chk("R7 act_ready untouched by activation", oa, 4'hF);
    issue(0, 1, row_in(1, 0), n, oc, oa);
    chk("R7 col_ready untouched by precharge", oc, 4'hF);
    chk("R7 other banks act_ready after precharge", {oa[3:2], oa[0]}, 3'b111);
  endtask

  task automatic t_fallback;
    int n; logic [3:0] oc, oa;
    @(negedge clk);
    prof_loading = 1;
    cmd_row = row_in(2, 3); #1;
    chk("R4 fallback trcd", cur_trcd, 6);
    chk("R4 fallback trp", cur_trp, 6);
    issue(1, 0, row_in(2, 3), n, oc, oa);
    chk("R4 fallback activation delay", n, 6);
    @(negedge clk);
    prof_loading = 0;
    cmd_row = row_in(2, 3); #1;
    chk("R4 fast again after loading", cur_trcd, 3);
  endtask

  task automatic t_config;
    int n; logic [3:0] oc, oa;
    set_delay(2, 2);
    set_delay(1, 8);
    issue(1, 2, row_in(2, 0), n, oc, oa);
    chk("R8 reprogrammed fast activation", n, 2);
    issue(0, 3, row_in(4, 0), n, oc, oa);
    chk("R8 reprogrammed standard precharge", n, 8);
    cmd_row = row_in(4, 0); #1;
    chk("R8 standard activation unchanged", cur_trcd, 6);
    cmd_row = row_in(5, 0); #1;
    chk("R8 fast precharge unchanged", cur_trp, 3);
  endtask

  task automatic t_profile_clear;
    set_profile(2, 0);
    cmd_row = row_in(2, 0); #1;
    chk("R9 cleared region now slow", cur_trcd, 6);
    cmd_row = row_in(5, 0); #1;
    chk("R9 neighbour region still fast", cur_trp, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_select();
    t_act_pre();
    t_independent();
    t_fallback();
    t_config();
    t_profile_clear();
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule